// File: doc/BRIEF.md
# Four-Line Serial Audio Transmitter

This block takes frames of eight 24-bit processed audio samples and sends them out on four serial data lines, two channels per line. It generates the shared bit clock and left/right frame clock itself by dividing the system clock, so one pair of clocks serves all four lines. A run-time slot map routes any input channel to any of the eight output slots, and the frame layout (I2S, left-justified or right-justified), the bit order and the transmitted word width are all selectable while the block runs.

Sample frames arrive through a valid/ready stream into a single staging register. The block takes a staged frame at the start of every 64-bit-clock frame. Settings and the slot map are sampled at that same moment, so every frame goes out with one consistent set of settings. If no frame is staged when a frame starts, that frame is sent as silence.

Top module: `audio_serial_tx`

## Requirements
- R1: The bit clock is low for HALF_DIV system clocks and then high for HALF_DIV system clocks. It resets low. The data lines and the left/right clock change only in the cycle in which the bit clock falls.
- R2: A frame has 64 bit periods. The left/right clock is low for the 32 periods of the left slot and high for the 32 periods of the right slot. Line L carries slot 2L when the clock is low and slot 2L+1 when it is high.
- R3: When fmt_sel is 0 (I2S), the first word bit goes out in the second bit period of a half-frame.
- R4: When fmt_sel is 1 (left-justified), or when it is 3, which behaves the same way, the first word bit goes out in the first bit period of a half-frame.
- R5: When fmt_sel is 2 (right-justified), the last word bit goes out in the 32nd bit period of a half-frame.
- R6: When lsb_first is 0, the word goes out most significant bit first. When it is 1, the word goes out least significant bit first.
- R7: width_sel picks the word width: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. The word sent is the upper bits of the 24-bit sample; the lower bits are dropped. Every bit period of a half-frame that falls outside the word drives 0.
- R8: slot_map[3s+2:3s] selects the input channel c for output slot s. Channel c is taken from s_data[24c+23:24c].
- R9: fmt_sel, lsb_first, width_sel and slot_map are sampled only as a frame starts. A change during a frame has no effect on the bits sent in that frame.
- R10: If no frame is staged when a frame starts, every data line sends all zeros for that whole frame.
- R11: s_ready is high exactly when the one-deep stage is empty, and it is high after reset. A transfer happens in a cycle with s_valid and s_ready both high. After a transfer s_ready stays low until the frame start that consumes the staged frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample frame valid |
| s_ready | output | 1 | Stage empty, a frame can be accepted |
| s_data | input | 192 | Eight 24-bit samples, channel c at bits 24c+23:24c |
| fmt_sel | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 left-justified |
| lsb_first | input | 1 | 1 sends the least significant bit first |
| width_sel | input | 2 | Word width code: 16/18/20/24 bits |
| slot_map | input | 24 | Three-bit channel select per output slot |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Left/right frame clock, low for the left slot |
| sdata | output | 4 | Serial data, one bit per line |

## Verification
The bench builds the block with HALF_DIV set to 2, so one bit period is 4 system clocks and one frame is 256 clocks. The other parameters keep their defaults. The short frame lets the bench run many whole frames in each format, bit order and width. It also reaches the corner cases: settings that change in the middle of a frame, frames that start with an empty stage, and frames offered back to back, where the stream has to apply back-pressure.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_RJ   = 2'd2,
    FMT_RSVD = 2'd3
  } tx_fmt_e;

  typedef struct packed {
    tx_fmt_e    fmt;
    logic       lsb_first;
    logic [1:0] wsel;
  } tx_cfg_t;

  function automatic int word_width(logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/audio_tx_clkgen.sv
module audio_tx_clkgen #(
  parameter int HALF_DIV  = 4,
  parameter int SLOT_BITS = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  output logic                            bclk,
  output logic                            adv,
  output logic [$clog2(2*SLOT_BITS)-1:0]  next_idx
);
  localparam int PH_W  = (HALF_DIV > 1) ? $clog2(2*HALF_DIV) : 1;
  localparam int IDX_W = $clog2(2*SLOT_BITS);

  logic [PH_W-1:0]  ph;
  logic [IDX_W-1:0] idx;

  assign adv      = (ph == PH_W'(2*HALF_DIV-1));
  assign next_idx = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= '0;
      idx  <= '1;
      bclk <= 1'b0;
    end else begin
      ph <= adv ? '0 : ph + 1'b1;
      if (ph == PH_W'(HALF_DIV-1)) bclk <= 1'b1;
      if (adv) begin
        bclk <= 1'b0;
        idx  <= next_idx;
      end
    end
  end
endmodule

// File: rtl/audio_tx_frame.sv
module audio_tx_frame
  import audio_tx_pkg::*;
#(
  parameter int CHANNELS = 8,
  parameter int SAMPLE_W = 24,
  parameter int MAP_W    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         s_valid,
  output logic                         s_ready,
  input  logic [CHANNELS*SAMPLE_W-1:0] s_data,
  input  tx_cfg_t                      cfg_in,
  input  logic [CHANNELS*MAP_W-1:0]    map_in,
  input  logic                         boundary,
  output tx_cfg_t                      cfg_eff,
  output logic [CHANNELS*SAMPLE_W-1:0] words_eff
);
  logic                         full;
  logic [CHANNELS*SAMPLE_W-1:0] stage, mapped, words_q;
  tx_cfg_t                      cfg_q;

  assign s_ready = !full;

  always_comb begin
    for (int s = 0; s < CHANNELS; s++) begin
      mapped[s*SAMPLE_W +: SAMPLE_W] = full
        ? stage[int'(map_in[s*MAP_W +: MAP_W])*SAMPLE_W +: SAMPLE_W]
        : '0;
    end
  end

  // The frame that starts this cycle already uses the newly sampled settings.
  assign cfg_eff   = boundary ? cfg_in : cfg_q;
  assign words_eff = boundary ? mapped : words_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      stage   <= '0;
      words_q <= '0;
      cfg_q   <= '0;
    end else begin
      if (boundary) begin
        cfg_q   <= cfg_in;
        words_q <= mapped;
      end
      if (s_valid && !full) begin
        full  <= 1'b1;
        stage <= s_data;
      end else if (boundary) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/audio_tx_bitsel.sv
module audio_tx_bitsel
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32,
  parameter int IDX_W     = 6
) (
  input  logic [SAMPLE_W-1:0] left_word,
  input  logic [SAMPLE_W-1:0] right_word,
  input  tx_cfg_t             cfg,
  input  logic [IDX_W-1:0]    idx,
  output logic                bit_o
);
  always_comb begin
    int w;
    int off;
    int k;
    logic [SAMPLE_W-1:0] word;
    w = word_width(cfg.wsel);
    case (cfg.fmt)
      FMT_I2S: off = 1;
      FMT_RJ:  off = SLOT_BITS - w;
      default: off = 0;
    endcase
    k     = int'(idx[IDX_W-2:0]) - off;
    word  = idx[IDX_W-1] ? right_word : left_word;
    bit_o = 1'b0;
    if (k >= 0 && k < w)
      bit_o = cfg.lsb_first ? word[SAMPLE_W-w+k] : word[SAMPLE_W-1-k];
  end
endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import audio_tx_pkg::*;
#(
  parameter int HALF_DIV  = 4,
  parameter int SLOT_BITS = 32,
  parameter int CHANNELS  = 8,
  parameter int SAMPLE_W  = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         s_valid,
  output logic                         s_ready,
  input  logic [CHANNELS*SAMPLE_W-1:0] s_data,
  input  logic [1:0]                   fmt_sel,
  input  logic                         lsb_first,
  input  logic [1:0]                   width_sel,
  input  logic [CHANNELS*$clog2(CHANNELS)-1:0] slot_map,
  output logic                         bclk,
  output logic                         lrclk,
  output logic [CHANNELS/2-1:0]        sdata
);
  localparam int LINES = CHANNELS / 2;
  localparam int MAP_W = $clog2(CHANNELS);
  localparam int IDX_W = $clog2(2*SLOT_BITS);

  logic                         adv, boundary;
  logic [IDX_W-1:0]             next_idx;
  tx_cfg_t                      cfg_in, cfg_eff;
  logic [CHANNELS*SAMPLE_W-1:0] words_eff;
  logic [LINES-1:0]             bits;
  logic                         lr_q;
  logic [LINES-1:0]             sd_q;

  assign cfg_in   = '{fmt: tx_fmt_e'(fmt_sel), lsb_first: lsb_first, wsel: width_sel};
  assign boundary = adv && (next_idx == '0);

  audio_tx_clkgen #(.HALF_DIV(HALF_DIV), .SLOT_BITS(SLOT_BITS)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .adv(adv), .next_idx(next_idx)
  );

  audio_tx_frame #(.CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W), .MAP_W(MAP_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .cfg_in(cfg_in), .map_in(slot_map), .boundary(boundary),
    .cfg_eff(cfg_eff), .words_eff(words_eff)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_line
    audio_tx_bitsel #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS), .IDX_W(IDX_W)) u_bitsel (
      .left_word (words_eff[(2*l)*SAMPLE_W +: SAMPLE_W]),
      .right_word(words_eff[(2*l+1)*SAMPLE_W +: SAMPLE_W]),
      .cfg(cfg_eff), .idx(next_idx), .bit_o(bits[l])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_q <= 1'b0;
      sd_q <= '0;
    end else if (adv) begin
      lr_q <= next_idx[IDX_W-1];
      sd_q <= bits;
    end
  end

  assign lrclk = lr_q;
  assign sdata = sd_q;
endmodule

// File: rtl/audio_serial_tx_chk.sv
module audio_serial_tx_chk #(
  parameter int SLOT_BITS = 32,
  parameter int LINES     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bclk,
  input logic             lrclk,
  input logic [LINES-1:0] sdata,
  input logic             s_valid,
  input logic             s_ready
);
  logic        bclk_d, lr_d, seen;
  int unsigned fall_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_d   <= 1'b0;
      lr_d     <= 1'b0;
      seen     <= 1'b0;
      fall_cnt <= 0;
    end else begin
      bclk_d <= bclk;
      lr_d   <= lrclk;
      if (lrclk != lr_d) begin
        fall_cnt <= 0;
        seen     <= 1'b1;
      end else if (bclk_d && !bclk) begin
        fall_cnt <= fall_cnt + 1;
      end
    end
  end

  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $fell(bclk)); // R1
  AST_LR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrclk) |-> $fell(bclk)); // R2
  AST_LR_HALF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((lrclk != lr_d) && seen) |-> (fall_cnt == SLOT_BITS-1)); // R2
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s_ready) |-> $past(s_valid)); // R11
endmodule

bind audio_serial_tx audio_serial_tx_chk #(.SLOT_BITS(SLOT_BITS), .LINES(CHANNELS/2)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
  .s_valid(s_valid), .s_ready(s_ready)
);

// File: tb/audio_serial_tx_bench.sv
module audio_serial_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int WD_LIMIT   = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [191:0] s_data = '0;
  logic [1:0]   fmt_sel = 2'd0;
  logic         lsb_first = 1'b0;
  logic [1:0]   width_sel = 2'd3;
  logic [23:0]  slot_map = '0;
  logic         bclk, lrclk;
  logic [3:0]   sdata;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R3";
  bit started = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_serial_tx #(.HALF_DIV(HALF_DIV)) u_audio_serial_tx (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .fmt_sel(fmt_sel), .lsb_first(lsb_first), .width_sel(width_sel), .slot_map(slot_map),
    .bclk(bclk), .lrclk(lrclk), .sdata(sdata)
  );

  // Behavioural reference model
  int           ph, n;
  logic         m_bclk, m_lr;
  logic [3:0]   m_sd;
  logic [191:0] stage_q[$];
  logic [23:0]  m_words[8];
  int           m_fmt, m_w;
  bit           m_lsb;

  function automatic int width_of(logic [1:0] c);
    return (c == 0) ? 16 : (c == 1) ? 18 : (c == 2) ? 20 : 24;
  endfunction

  function automatic logic model_bit(logic [23:0] wd, int f, bit lsb, int w, int pos);
    int start;
    int j;
    logic [23:0] t;
    start = (f == 0) ? 1 : (f == 2) ? 32 - w : 0;
    t = wd >> (24 - w);
    j = pos - start;
    if (j < 0 || j >= w) return 1'b0;
    return lsb ? t[j] : t[w-1-j];
  endfunction

  always @(posedge clk) begin
    bit acc;
    bit bnd;
    logic [191:0] fr;
    if (!rst_n) begin
      ph = 0; n = 63; m_bclk = 0; m_lr = 0; m_sd = '0;
      stage_q.delete();
      for (int s = 0; s < 8; s++) m_words[s] = '0;
      m_fmt = 0; m_lsb = 0; m_w = 16;
      started = 1;
    end else begin
      acc = s_valid && (stage_q.size() == 0);
      bnd = 0;
      if (ph == HALF_DIV-1) m_bclk = 1;
      if (ph == 2*HALF_DIV-1) begin
        m_bclk = 0;
        n = (n + 1) % 64;
        if (n == 0) begin
          bnd = 1;
          fr = (stage_q.size() != 0) ? stage_q[0] : '0;
          m_fmt = (fmt_sel == 2'd3) ? 1 : int'(fmt_sel);
          m_lsb = lsb_first;
          m_w = width_of(width_sel);
          for (int s = 0; s < 8; s++) m_words[s] = fr[int'(slot_map[3*s +: 3])*24 +: 24];
        end
        m_lr = (n >= 32);
        for (int l = 0; l < 4; l++)
          m_sd[l] = model_bit(m_words[2*l + (n >= 32 ? 1 : 0)], m_fmt, m_lsb, m_w, n % 32);
      end
      ph = (ph + 1) % (2*HALF_DIV);
      if (bnd && stage_q.size() != 0) void'(stage_q.pop_front());
      if (acc) stage_q.push_back(s_data);
    end
  end

  task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && rst_n && !done) begin
      check("R1", "bclk", {3'b0, bclk}, {3'b0, m_bclk});
      check("R2", "lrclk", {3'b0, lrclk}, {3'b0, m_lr});
      check("R11", "s_ready", {3'b0, s_ready}, {3'b0, (stage_q.size() == 0)});
      check(cur_req, "sdata", sdata, m_sd);
    end
  end

  task automatic report();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  function automatic logic [191:0] mk_frame(int seed);
    logic [191:0] f;
    for (int c = 0; c < 8; c++)
      f[c*24 +: 24] = 24'(seed * 32'h9E3779 + c * 32'h5A5A5) ^ 24'hC3A51F;
    return f;
  endfunction

  task automatic send_frames(int count, int seed);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      while (!s_ready) @(negedge clk);
      s_valid = 1'b1;
      s_data  = mk_frame(seed + i);
      @(negedge clk);
      s_valid = 1'b0;
    end
  endtask

  function automatic logic [23:0] ident_map();
    logic [23:0] m;
    for (int s = 0; s < 8; s++) m[3*s +: 3] = 3'(s);
    return m;
  endfunction

  function automatic logic [23:0] rev_map();
    logic [23:0] m;
    for (int s = 0; s < 8; s++) m[3*s +: 3] = 3'(7 - s);
    return m;
  endfunction

  task automatic phase(string req, logic [1:0] f, bit lsb, logic [1:0] w, logic [23:0] mp, int seed);
    @(negedge clk);
    cur_req = req; fmt_sel = f; lsb_first = lsb; width_sel = w; slot_map = mp;
    send_frames(3, seed);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // reset state, R1 and R11
    check("R1", "reset bclk", {3'b0, bclk}, 4'h0);
    check("R2", "reset lrclk", {3'b0, lrclk}, 4'h0);
    check("R10", "reset sdata", sdata, 4'h0);
    check("R11", "reset s_ready", {3'b0, s_ready}, 4'h1);
    rst_n = 1'b1;
    phase("R3", 2'd0, 0, 2'd3, ident_map(), 10);
    phase("R4", 2'd1, 0, 2'd3, ident_map(), 20);
    phase("R4", 2'd3, 0, 2'd3, ident_map(), 30);
    phase("R5", 2'd2, 0, 2'd0, ident_map(), 40);
    phase("R6", 2'd2, 1, 2'd2, ident_map(), 50);
    phase("R6", 2'd1, 1, 2'd1, ident_map(), 60);
    phase("R7", 2'd0, 0, 2'd1, ident_map(), 70);
    phase("R7", 2'd1, 0, 2'd2, ident_map(), 80);
    phase("R8", 2'd0, 0, 2'd3, rev_map(), 90);
    phase("R8", 2'd2, 1, 2'd3, 24'o55555555, 100);
    // R9: settings toggle in the middle of frames
    cur_req = "R9";
    fork
      send_frames(4, 110);
      for (int i = 0; i < 30; i++) begin
        repeat (37) @(negedge clk);
        fmt_sel = 2'(i); lsb_first = i[1]; width_sel = 2'(i + 1);
        slot_map = (i % 2 == 1) ? rev_map() : ident_map();
      end
    join
    // R10: no frames for a while, output must be silent
    @(negedge clk);
    cur_req = "R10";
    repeat (3 * 64 * 2 * HALF_DIV) @(negedge clk);
    phase("R11", 2'd0, 0, 2'd3, ident_map(), 130);
    repeat (2 * 64 * 2 * HALF_DIV) @(negedge clk);
    report();
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end
endmodule